// File: doc/BRIEF.md
# Masked Find-Minimum Comparator Tree

This block selects the smallest priority value among N entries of W bits each. Only the entries whose eligibility bit is set take part. A scheduler uses it to pick the next flow to serve when many flows can be switched on or off in a single cycle. The eligibility vector and the values are sampled fresh on every evaluation, so no state is carried over from one pick to the next.

The search runs as a binary tree of log2(N) levels of two-input compare-and-select nodes. Each node passes up the smaller eligible value, the index of its winner and a valid bit. Each node compares in groups of bits, starting at the most significant group, so a decision in the high bits can settle before the low groups are examined. A parameter inserts a register stage after every K levels. With K set to zero the tree is purely combinational.

Top module: `minfind_tree`

## Requirements
- R1: When at least one entry is eligible, `min_val_o` equals the smallest value among the eligible entries. Entry i occupies bits [i*W +: W] of `prio_i`, and its eligibility is bit i of `elig_i`.
- R2: `min_idx_o` gives the position i of the winning entry. Tree level L (counted from 1 at the leaves) sets bit L-1 of this index: 0 when the left (lower) half wins, 1 when the right half wins.
- R3: An ineligible entry never wins, even when its value is smaller than every eligible value.
- R4: When several eligible entries share the minimum value, the one with the lowest index wins.
- R5: When no entry is eligible, `min_ok_o` is 0 and both `min_val_o` and `min_idx_o` are 0. Otherwise `min_ok_o` is 1.
- R6: With STAGE_EVERY = K > 0, a register stage follows each level L where L mod K = 0. The result therefore appears floor(log2(N)/K) clock cycles after the inputs are sampled. With K = 0 the result is combinational.
- R7: A new input set can be applied on every clock cycle. Each result depends only on the inputs of its own cycle.
- R8: An active-low asynchronous reset clears every pipeline stage. While reset is held, and until the first input set has passed through the pipeline, the outputs show "no eligible entry".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pipeline stages |
| rst_n | input | 1 | Asynchronous active-low reset |
| elig_i | input | N | Eligibility bit for each entry |
| prio_i | input | N*W | Priority values; entry i at bits [i*W +: W] |
| min_val_o | output | W | Smallest eligible value, 0 when none |
| min_idx_o | output | log2(N) | Index of the winning entry, 0 when none |
| min_ok_o | output | 1 | At least one entry was eligible |

## Verification
In the pipelined build, one cycle carries two things at once: a new input set enters the first stage while the result of the previous set leaves the last stage. The bench provokes this by driving the vector table back to back, one row per clock. It judges each row's outputs one clock later against that row's own expected value, index and valid bit, so any leakage between neighbouring rows shows up as a mismatch. Inside a single evaluation, masking and the tie rule act in the same node. Rows that place an ineligible smaller value, or an equal value, next to the true winner test how the two interact.

// File: rtl/minfind_pkg.sv
package minfind_pkg;

   // Outcome of one tree node: which child is passed upward
   typedef enum logic {
      PICK_LEFT  = 1'b0,
      PICK_RIGHT = 1'b1
   } pick_e;

   // True when a register stage follows tree level lvl (1-based)
   function automatic bit stage_after(input int lvl, input int every);
      return (every > 0) && ((lvl % every) == 0);
   endfunction

   // Number of register stages in a tree of the given depth
   function automatic int stage_count(input int levels, input int every);
      return (every > 0) ? (levels / every) : 0;
   endfunction

endpackage

// File: rtl/minfind_cmp.sv
// Group-wise magnitude compare, most significant group decides first.
module minfind_cmp #(
   parameter int W   = 24,
   parameter int GRP = 4
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic         a_lt_b_o
);
   localparam int NG = (W + GRP - 1) / GRP;
   localparam int PW = NG * GRP;

   logic [PW-1:0] a_p, b_p;
   logic [NG-1:0] grp_lt, grp_eq;

   assign a_p = PW'(a_i);
   assign b_p = PW'(b_i);

   genvar g;
   generate
      for (g = 0; g < NG; g++) begin : grp
         assign grp_lt[g] = a_p[g*GRP +: GRP] <  b_p[g*GRP +: GRP];
         assign grp_eq[g] = a_p[g*GRP +: GRP] == b_p[g*GRP +: GRP];
      end
   endgenerate

   // First unequal group scanning down from the top settles the outcome
   always_comb begin
      logic settled;
      a_lt_b_o = 1'b0;
      settled  = 1'b0;
      for (int k = NG - 1; k >= 0; k--) begin
         if (!settled && !grp_eq[k]) begin
            a_lt_b_o = grp_lt[k];
            settled  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/minfind_node.sv
// One compare-and-select node with masked inputs.
module minfind_node
   import minfind_pkg::*;
#(
   parameter int W   = 24,
   parameter int IW  = 8,
   parameter int LVL = 1,
   parameter int GRP = 4
) (
   input  logic          l_ok_i,
   input  logic [W-1:0]  l_val_i,
   input  logic [IW-1:0] l_idx_i,
   input  logic          r_ok_i,
   input  logic [W-1:0]  r_val_i,
   input  logic [IW-1:0] r_idx_i,
   output logic          o_ok_o,
   output logic [W-1:0]  o_val_o,
   output logic [IW-1:0] o_idx_o
);
   logic  r_below;
   pick_e pick;

   minfind_cmp #(.W(W), .GRP(GRP)) u_cmp (
      .a_i      (r_val_i),
      .b_i      (l_val_i),
      .a_lt_b_o (r_below)
   );

   // Right wins only if eligible and strictly smaller, or left is masked
   assign pick = (r_ok_i && (!l_ok_i || r_below)) ? PICK_RIGHT : PICK_LEFT;

   always_comb begin
      o_ok_o = l_ok_i | r_ok_i;
      if (pick == PICK_RIGHT) begin
         o_val_o = r_val_i;
         o_idx_o = r_idx_i;
      end else begin
         o_val_o = l_val_i;
         o_idx_o = l_idx_i;
      end
      o_idx_o[LVL-1] = (pick == PICK_RIGHT);
   end
endmodule

// File: rtl/minfind_stage.sv
// Optional pipeline register; a wire when EN is 0.
module minfind_stage #(
   parameter int WIDTH = 8,
   parameter bit EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (EN) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_o <= '0;
            else        q_o <= d_i;
         end
      end else begin : g_wire
         assign q_o = d_i;
      end
   endgenerate
endmodule

// File: rtl/minfind_tree.sv
module minfind_tree
   import minfind_pkg::*;
#(
   parameter int N           = 256,
   parameter int W           = 24,
   parameter int GRP         = 4,
   parameter int STAGE_EVERY = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N-1:0]          elig_i,
   input  logic [N*W-1:0]        prio_i,
   output logic [W-1:0]          min_val_o,
   output logic [$clog2(N)-1:0]  min_idx_o,
   output logic                  min_ok_o
);
   localparam int LEVELS = $clog2(N);
   localparam int IW     = LEVELS;
   localparam int LAT    = stage_count(LEVELS, STAGE_EVERY);
   localparam int PKW    = 1 + IW + W;

   // Elaboration-time parameter checks
   generate
      if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_n
         $error("minfind_tree: N must be a power of two >= 2");
      end
      if (W < 1) begin : g_bad_w
         $error("minfind_tree: W must be at least 1");
      end
      if (GRP < 1) begin : g_bad_grp
         $error("minfind_tree: GRP must be at least 1");
      end
      if (STAGE_EVERY < 0) begin : g_bad_k
         $error("minfind_tree: STAGE_EVERY must be >= 0");
      end
   endgenerate

   genvar lv, j;
   generate
      for (lv = 0; lv <= LEVELS; lv++) begin : lvl
         localparam int CNT = N >> lv;
         logic          ok  [CNT];
         logic [W-1:0]  val [CNT];
         logic [IW-1:0] idx [CNT];

         if (lv == 0) begin : g_leaf
            for (j = 0; j < CNT; j++) begin : leaf
               assign ok[j]  = elig_i[j];
               assign val[j] = prio_i[j*W +: W];
               assign idx[j] = '0;
            end
         end else begin : g_nodes
            for (j = 0; j < CNT; j++) begin : nd
               logic          c_ok;
               logic [W-1:0]  c_val;
               logic [IW-1:0] c_idx;
               logic [PKW-1:0] q;

               minfind_node #(.W(W), .IW(IW), .LVL(lv), .GRP(GRP)) u_node (
                  .l_ok_i  (lvl[lv-1].ok[2*j]),
                  .l_val_i (lvl[lv-1].val[2*j]),
                  .l_idx_i (lvl[lv-1].idx[2*j]),
                  .r_ok_i  (lvl[lv-1].ok[2*j+1]),
                  .r_val_i (lvl[lv-1].val[2*j+1]),
                  .r_idx_i (lvl[lv-1].idx[2*j+1]),
                  .o_ok_o  (c_ok),
                  .o_val_o (c_val),
                  .o_idx_o (c_idx)
               );

               minfind_stage #(.WIDTH(PKW), .EN(stage_after(lv, STAGE_EVERY))) u_stg (
                  .clk   (clk),
                  .rst_n (rst_n),
                  .d_i   ({c_ok, c_idx, c_val}),
                  .q_o   (q)
               );

               assign ok[j]  = q[PKW-1];
               assign idx[j] = q[W +: IW];
               assign val[j] = q[W-1:0];
            end
         end
      end
   endgenerate

   // Root: force a clean zero result when nothing was eligible
   assign min_ok_o  = lvl[LEVELS].ok[0];
   assign min_val_o = min_ok_o ? lvl[LEVELS].val[0] : '0;
   assign min_idx_o = min_ok_o ? lvl[LEVELS].idx[0] : '0;
endmodule

// File: rtl/minfind_tree_chk.sv
module minfind_tree_chk #(
   parameter int N   = 256,
   parameter int W   = 24,
   parameter int LAT = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [N-1:0]         elig_i,
   input logic [W-1:0]         min_val_o,
   input logic [$clog2(N)-1:0] min_idx_o,
   input logic                 min_ok_o
);
   // Eligibility delayed by the pipeline latency
   logic [N-1:0] elig_d [LAT+1];
   assign elig_d[0] = elig_i;

   genvar d;
   generate
      for (d = 1; d <= LAT; d++) begin : dly
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) elig_d[d] <= '0;
            else        elig_d[d] <= elig_d[d-1];
         end
      end
   endgenerate

   // R5
   no_elig_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !min_ok_o |-> (min_val_o == '0 && min_idx_o == '0));

   // R7
   ok_tracks_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      min_ok_o == (|elig_d[LAT]));

   // R3
   winner_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      min_ok_o |-> elig_d[LAT][min_idx_o]);

   // R8
   always @(posedge clk) begin
      if (!rst_n && LAT > 0) begin
         reset_clear_chk: assert (!min_ok_o);
      end
   end
endmodule

bind minfind_tree minfind_tree_chk #(.N(N), .W(W), .LAT(LAT)) u_chk (.*);

// File: tb/minfind_tree_bench.sv
module minfind_tree_bench;
   localparam int N  = 8;
   localparam int W  = 8;
   localparam int IW = 3;
   localparam int NV = 11;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    elig = '0;
   logic [N*W-1:0]  prio = '0;
   logic [W-1:0]    min_val;
   logic [IW-1:0]   min_idx;
   logic            min_ok;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   // 3 levels, stage after level 2 -> one cycle latency (R6)
   minfind_tree #(.N(N), .W(W), .GRP(3), .STAGE_EVERY(2)) u_minfind_tree (
      .clk       (clk),
      .rst_n     (rst_n),
      .elig_i    (elig),
      .prio_i    (prio),
      .min_val_o (min_val),
      .min_idx_o (min_idx),
      .min_ok_o  (min_ok)
   );

   // Entry i is byte i of prio (entry 7 is the leftmost byte)
   localparam logic [N-1:0] T_ELIG [NV] = '{
      8'hFF, 8'hFF, 8'h7F, 8'hF0, 8'hFF, 8'h00,
      8'h20, 8'h81, 8'h0C, 8'h60, 8'hFE};
   localparam logic [N*W-1:0] T_PRIO [NV] = '{
      64'h80706050_40302010,  // R1 ascending
      64'h01706050_40302010,  // R2 top entry smallest
      64'h01706050_40302010,  // R3 smallest masked off
      64'h33445566_01020304,  // R3 lower half masked
      64'h09092020_09303030,  // R4 three-way tie
      64'h00000000_00000000,  // R5 nothing eligible
      64'hFFFFFFFF_FFFFFFFF,  // R2 single eligible at 5
      64'h00111111_11111100,  // R4 tie at both ends
      64'hFFFFFFFF_8485FFFF,  // R1 differ only in low group
      64'h007F8000_00000000,  // R1 differ in top bit, small masked
      64'h42424242_42424242}; // R4 all equal, entry 0 masked
   localparam logic         T_OK  [NV] = '{1,1,1,1,1,0,1,1,1,1,1};
   localparam logic [W-1:0] T_VAL [NV] = '{
      8'h10, 8'h01, 8'h10, 8'h33, 8'h09, 8'h00,
      8'hFF, 8'h00, 8'h84, 8'h7F, 8'h42};
   localparam logic [IW-1:0] T_IDX [NV] = '{
      3'd0, 3'd7, 3'd0, 3'd7, 3'd3, 3'd0,
      3'd5, 3'd0, 3'd3, 3'd6, 3'd1};
   localparam int T_REQ [NV] = '{1, 2, 3, 3, 4, 5, 2, 4, 1, 1, 4};

   task automatic check(input string req, input logic ok_e,
                        input logic [W-1:0] val_e, input logic [IW-1:0] idx_e);
      tests++;
      if (min_ok !== ok_e || min_val !== val_e || min_idx !== idx_e) begin
         fails++;
         $display("FAIL %s: got ok=%0b val=%02h idx=%0d, expected ok=%0b val=%02h idx=%0d",
                  req, min_ok, min_val, min_idx, ok_e, val_e, idx_e);
      end
   endtask

   initial begin
      // R8: outputs clear while reset is held
      repeat (3) @(negedge clk);
      check("R8 reset", 1'b0, 8'h00, 3'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 after reset", 1'b0, 8'h00, 3'd0);

      // Table walked back to back: row i checked while row i+1 enters (R7)
      for (int i = 0; i <= NV; i++) begin
         @(negedge clk);
         if (i > 0)
            check($sformatf("R%0d/R7 row %0d", T_REQ[i-1], i-1),
                  T_OK[i-1], T_VAL[i-1], T_IDX[i-1]);
         if (i < NV) begin
            elig = T_ELIG[i];
            prio = T_PRIO[i];
         end
      end

      // R5: empty set after a valid result
      elig = '0;
      @(negedge clk);
      check("R5 empty", 1'b0, 8'h00, 3'd0);

      // R6: result is not visible before the register stage captures it
      elig = 8'h01;
      prio = 64'hFFFFFFFF_FFFFFF05;
      #1;
      check("R6 before edge", 1'b0, 8'h00, 3'd0);
      @(negedge clk);
      check("R6 one cycle later", 1'b1, 8'h05, 3'd0);

      // R3: masked entry with the smallest value next to eligible one
      elig = 8'h02;
      prio = 64'hFFFFFFFF_FFFF0900;
      @(negedge clk);
      check("R3 masked neighbour", 1'b1, 8'h09, 3'd1);

      // R8: asynchronous reset clears a held result immediately
      #1 rst_n = 1'b0;
      #1;
      check("R8 async clear", 1'b0, 8'h00, 3'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R3 after reset", 1'b1, 8'h09, 3'd1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule